// File: doc/BRIEF.md
# PCI Interrupt Router and CPU Trigger

This block takes interrupt events raised by devices on a PCI bus and decides two things for each one. First, it converts the pair (slot number, interrupt pin 0..3) into an internal bridge interrupt line number. The conversion uses a fixed table. One multi-function slot keeps its four pins apart. Two single-function slots collapse all of their pins onto one line each. A group of add-in slots gets lines that rotate with slot and pin, so neighbouring cards spread across lines. Any slot outside the table keeps its raw pin number.

Second, the block decides how the event drives a single CPU interrupt wire. Each internal line has one bit in an edge-mode mask and one bit in a polarity mask, and the bit is picked by the line's offset from the line base (32). When the edge bit is set, the event fires a one-cycle pulse on the CPU interrupt. When it is clear, the CPU interrupt is driven to the polarity bit and holds there. Events whose line falls outside the configured line window leave the CPU interrupt alone.

The routed line number and the CPU interrupt are registered. Both appear one clock after the event is presented. The masks are sampled in the same cycle as the event.

Top module: `irq_router`

## Requirements
- R1: While `rst` is high at a rising clock edge, `line_vld`, `line_mapped` and `cpu_irq` go to 0 and `line_num` goes to 0 after that edge.
- R2: An event from slot 5 on pin p reports `line_num` = 32 + p one cycle after `evt_vld`, with `line_mapped` = 1.
- R3: An event from slot 6 reports `line_num` = 36 and an event from slot 7 reports 37, whatever the pin, with `line_mapped` = 1.
- R4: An event from slot s, where 8 <= s <= 12, on pin p reports `line_num` = 38 + (s - 8) + p, with `line_mapped` = 1.
- R5: An event from any other slot reports `line_num` = p (the pin, untranslated), with `line_mapped` = 0.
- R6: For a mapped event whose line L has `edge_mask[L-32]` = 1 at the event cycle, `cpu_irq` is 1 in exactly the next cycle. If no further mapped event follows, it is 0 in the cycle after that and stays 0.
- R7: For a mapped event whose line L has `edge_mask[L-32]` = 0, `cpu_irq` equals `pol_mask[L-32]` (sampled at the event cycle) from the next cycle on, until the next mapped event.
- R8: An unmapped event (line offset outside 0..31) does not change `cpu_irq`. A held level stays, and a pulse still ends after its one cycle.
- R9: `line_vld` is 1 exactly in the cycle after a cycle with `evt_vld` = 1. Otherwise it is 0, and `line_num` and `line_mapped` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| evt_vld | input | 1 | An interrupt level-change event is presented this cycle |
| evt_slot | input | 5 | PCI slot number of the requesting device |
| evt_pin | input | 2 | Interrupt pin of the device, 0..3 |
| edge_mask | input | 32 | Per-line edge-mode bits, indexed by line minus 32 |
| pol_mask | input | 32 | Per-line level polarity bits, indexed by line minus 32 |
| line_vld | output | 1 | Registered: the routed line below belongs to last cycle's event |
| line_num | output | 8 | Registered routed line number |
| line_mapped | output | 1 | Registered: routed line lies in the configured window |
| cpu_irq | output | 1 | Registered CPU interrupt wire |

## Verification
The router is driven with a sweep over every slot code and every pin, so each table branch is covered: the multi-function slot, the two collapsing slots, each add-in slot with rotation, and pass-through slots. The sweep also separates an off-by-one in the add-in offset from a wrong pin treatment. The trigger is driven with back-to-back events, level events followed by idle cycles, and pulses followed by idle cycles. Unmapped events arrive while a level is held, and masks change in the cycle right after an event. These patterns separate pulse length, level hold, use of the mask at event time versus a later time, and wrong handling of unmapped events. A behavioural reference model predicts every output on every clock.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  // Bus-side event coding
  parameter int SLOT_W      = 5;
  parameter int PIN_W       = 2;
  // Internal line numbering
  parameter int LINE_W      = 8;
  parameter int LINE_BASE   = 32;
  parameter int NUM_LINES   = 32;
  // Routing table shape
  parameter int MULTI_SLOT  = 5;   // pins kept apart
  parameter int SOLO_SLOT_A = 6;   // all pins -> one line
  parameter int SOLO_OFS_A  = 4;
  parameter int SOLO_SLOT_B = 7;
  parameter int SOLO_OFS_B  = 5;
  parameter int ADDIN_FIRST = 8;   // rotating add-in slots
  parameter int ADDIN_COUNT = 5;
  parameter int ADDIN_OFS   = 6;

  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  typedef struct packed {
    logic              vld;
    logic [LINE_W-1:0] num;
    logic              mapped;
  } line_rec_t;
endpackage

// File: rtl/irq_slot_map.sv
// Combinational slot/pin -> internal line translation.
module irq_slot_map
  import irq_router_pkg::*;
#(
  parameter int P_SLOT_W      = SLOT_W,
  parameter int P_PIN_W       = PIN_W,
  parameter int P_LINE_W      = LINE_W,
  parameter int P_LINE_BASE   = LINE_BASE,
  parameter int P_MULTI_SLOT  = MULTI_SLOT,
  parameter int P_SOLO_SLOT_A = SOLO_SLOT_A,
  parameter int P_SOLO_OFS_A  = SOLO_OFS_A,
  parameter int P_SOLO_SLOT_B = SOLO_SLOT_B,
  parameter int P_SOLO_OFS_B  = SOLO_OFS_B,
  parameter int P_ADDIN_FIRST = ADDIN_FIRST,
  parameter int P_ADDIN_COUNT = ADDIN_COUNT,
  parameter int P_ADDIN_OFS   = ADDIN_OFS
) (
  input  logic [P_SLOT_W-1:0] slot,
  input  logic [P_PIN_W-1:0]  pin,
  output logic [P_LINE_W-1:0] line
);
  localparam logic [P_SLOT_W-1:0] MULTI_S  = P_SLOT_W'(P_MULTI_SLOT);
  localparam logic [P_SLOT_W-1:0] SOLO_A_S = P_SLOT_W'(P_SOLO_SLOT_A);
  localparam logic [P_SLOT_W-1:0] SOLO_B_S = P_SLOT_W'(P_SOLO_SLOT_B);
  localparam logic [P_LINE_W-1:0] BASE_L   = P_LINE_W'(P_LINE_BASE);
  localparam logic [P_LINE_W-1:0] SOLO_A_L = P_LINE_W'(P_LINE_BASE + P_SOLO_OFS_A);
  localparam logic [P_LINE_W-1:0] SOLO_B_L = P_LINE_W'(P_LINE_BASE + P_SOLO_OFS_B);

  logic [P_LINE_W-1:0] pin_ext;
  logic [P_LINE_W-1:0] pin_mod4;
  assign pin_ext  = P_LINE_W'(pin);
  assign pin_mod4 = pin_ext & P_LINE_W'(3);

  // One comparator and one adder per add-in slot
  logic [P_ADDIN_COUNT-1:0] addin_sel;
  logic [P_LINE_W-1:0]      addin_line [P_ADDIN_COUNT];

  for (genvar g = 0; g < P_ADDIN_COUNT; g++) begin : g_addin
    localparam logic [P_SLOT_W-1:0] ADD_S = P_SLOT_W'(P_ADDIN_FIRST + g);
    localparam logic [P_LINE_W-1:0] ADD_L = P_LINE_W'(P_LINE_BASE + P_ADDIN_OFS + g);
    assign addin_sel[g]  = (slot == ADD_S);
    assign addin_line[g] = ADD_L + pin_ext;
  end

  logic [P_LINE_W-1:0] addin_pick;
  always_comb begin
    addin_pick = '0;
    for (int k = 0; k < P_ADDIN_COUNT; k++) begin
      if (addin_sel[k]) addin_pick = addin_line[k];
    end
  end

  always_comb begin
    if (slot == MULTI_S)       line = BASE_L + pin_mod4;
    else if (slot == SOLO_A_S) line = SOLO_A_L;
    else if (slot == SOLO_B_S) line = SOLO_B_L;
    else if (|addin_sel)       line = addin_pick;
    else                       line = pin_ext;
  end
endmodule

// File: rtl/irq_line_cfg.sv
// Window check on a line number and pick of its edge / polarity bits.
module irq_line_cfg
  import irq_router_pkg::*;
#(
  parameter int P_LINE_W    = LINE_W,
  parameter int P_LINE_BASE = LINE_BASE,
  parameter int P_NUM_LINES = NUM_LINES,
  localparam int L_IDX_W    = (P_NUM_LINES > 1) ? $clog2(P_NUM_LINES) : 1
) (
  input  logic [P_LINE_W-1:0]    line,
  input  logic [P_NUM_LINES-1:0] edge_mask,
  input  logic [P_NUM_LINES-1:0] pol_mask,
  output logic                   in_win,
  output logic                   edge_bit,
  output logic                   pol_bit
);
  localparam logic [P_LINE_W-1:0] BASE_L = P_LINE_W'(P_LINE_BASE);
  localparam logic [P_LINE_W-1:0] CNT_L  = P_LINE_W'(P_NUM_LINES);

  logic [P_LINE_W-1:0] ofs;
  logic [L_IDX_W-1:0]  idx;

  assign ofs    = line - BASE_L;
  assign in_win = (line >= BASE_L) && (ofs < CNT_L);
  assign idx    = ofs[L_IDX_W-1:0];

  always_comb begin
    edge_bit = 1'b0;
    pol_bit  = 1'b0;
    if (in_win) begin
      edge_bit = edge_mask[idx];
      pol_bit  = pol_mask[idx];
    end
  end
endmodule

// File: rtl/irq_cpu_drive.sv
// Registered outputs: routed line record and the CPU interrupt wire.
module irq_cpu_drive
  import irq_router_pkg::*;
#(
  parameter int P_LINE_W = LINE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                evt_vld,
  input  logic [P_LINE_W-1:0] line,
  input  logic                in_win,
  input  logic                edge_bit,
  input  logic                pol_bit,
  output logic                line_vld,
  output logic [P_LINE_W-1:0] line_num,
  output logic                line_mapped,
  output logic                cpu_irq
);
  // Resting level of the wire when no pulse is active
  logic rest_q;
  logic act;

  assign act = evt_vld && in_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_vld    <= 1'b0;
      line_num    <= '0;
      line_mapped <= 1'b0;
    end else begin
      line_vld <= evt_vld;
      if (evt_vld) begin
        line_num    <= line;
        line_mapped <= in_win;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rest_q  <= 1'b0;
      cpu_irq <= 1'b0;
    end else if (act && edge_bit) begin
      rest_q  <= 1'b0;     // pulse then fall back low
      cpu_irq <= 1'b1;
    end else if (act) begin
      rest_q  <= pol_bit;
      cpu_irq <= pol_bit;
    end else begin
      cpu_irq <= rest_q;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 evt_vld,
  input  logic [SLOT_W-1:0]    evt_slot,
  input  logic [PIN_W-1:0]     evt_pin,
  input  logic [NUM_LINES-1:0] edge_mask,
  input  logic [NUM_LINES-1:0] pol_mask,
  output logic                 line_vld,
  output logic [LINE_W-1:0]    line_num,
  output logic                 line_mapped,
  output logic                 cpu_irq
);
  logic [LINE_W-1:0] line_c;
  logic              in_win_c;
  logic              edge_c;
  logic              pol_c;

  irq_slot_map u_map (
    .slot (evt_slot),
    .pin  (evt_pin),
    .line (line_c)
  );

  irq_line_cfg u_cfg (
    .line      (line_c),
    .edge_mask (edge_mask),
    .pol_mask  (pol_mask),
    .in_win    (in_win_c),
    .edge_bit  (edge_c),
    .pol_bit   (pol_c)
  );

  irq_cpu_drive u_drv (
    .clk         (clk),
    .rst         (rst),
    .evt_vld     (evt_vld),
    .line        (line_c),
    .in_win      (in_win_c),
    .edge_bit    (edge_c),
    .pol_bit     (pol_c),
    .line_vld    (line_vld),
    .line_num    (line_num),
    .line_mapped (line_mapped),
    .cpu_irq     (cpu_irq)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 evt_vld,
  input logic [NUM_LINES-1:0] edge_mask,
  input logic [NUM_LINES-1:0] pol_mask,
  input logic                 line_vld,
  input logic [LINE_W-1:0]    line_num,
  input logic                 line_mapped,
  input logic                 cpu_irq
);
  localparam logic [LINE_W-1:0] BASE_L = LINE_W'(LINE_BASE);

  logic [NUM_LINES-1:0] edge_q;
  logic [NUM_LINES-1:0] pol_q;
  logic [IDX_W-1:0]     idx;

  always_ff @(posedge clk) begin
    edge_q <= edge_mask;
    pol_q  <= pol_mask;
  end

  assign idx = IDX_W'(line_num - BASE_L);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!line_vld && !cpu_irq && !line_mapped));

  // R4
  mapped_window_chk: assert property (@(posedge clk) disable iff (rst)
    (line_vld && line_mapped) |-> (line_num >= BASE_L && line_num < BASE_L + LINE_W'(NUM_LINES)));

  // R5
  passthru_small_chk: assert property (@(posedge clk) disable iff (rst)
    (line_vld && !line_mapped) |-> (line_num < LINE_W'(1 << PIN_W)));

  // R6
  pulse_high_chk: assert property (@(posedge clk) disable iff (rst)
    (line_vld && line_mapped && edge_q[idx]) |-> cpu_irq);

  // R6
  pulse_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (line_vld && line_mapped && edge_q[idx] && !evt_vld) |=> !cpu_irq);

  // R7
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (line_vld && line_mapped && !edge_q[idx]) |-> (cpu_irq == pol_q[idx]));

  // R8
  no_rise_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_irq) |-> (line_vld && line_mapped));

  // R9
  vld_follows_evt_chk: assert property (@(posedge clk) disable iff (rst)
    !evt_vld |=> !line_vld);
endmodule

bind irq_router irq_router_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .evt_vld     (evt_vld),
  .edge_mask   (edge_mask),
  .pol_mask    (pol_mask),
  .line_vld    (line_vld),
  .line_num    (line_num),
  .line_mapped (line_mapped),
  .cpu_irq     (cpu_irq)
);

// File: tb/irq_router_test.sv
module irq_router_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_vld = 1'b0;
  logic [4:0]  evt_slot = '0;
  logic [1:0]  evt_pin = '0;
  logic [31:0] edge_mask = '0;
  logic [31:0] pol_mask = '0;
  logic        line_vld;
  logic [7:0]  line_num;
  logic        line_mapped;
  logic        cpu_irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit started = 0;

  // reference model state
  bit    m_vld, m_map, m_irq, m_rest;
  int    m_line;
  string t_line = "R1", t_irq = "R1", t_vld = "R1";

  always #10 clk = ~clk;

  irq_router uut (
    .clk(clk), .rst(rst), .evt_vld(evt_vld), .evt_slot(evt_slot),
    .evt_pin(evt_pin), .edge_mask(edge_mask), .pol_mask(pol_mask),
    .line_vld(line_vld), .line_num(line_num), .line_mapped(line_mapped),
    .cpu_irq(cpu_irq)
  );

  function automatic int ref_line(int s, int p);
    if (s == 5) return 32 + (p % 4);
    if (s == 6) return 36;
    if (s == 7) return 37;
    if (s >= 8 && s <= 12) return 38 + (s - 8) + p;
    return p;
  endfunction

  function automatic string ref_tag(int s);
    if (s == 5) return "R2";
    if (s == 6 || s == 7) return "R3";
    if (s >= 8 && s <= 12) return "R4";
    return "R5";
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    cyc <= cyc + 1;
    if (rst) begin
      m_vld = 0; m_map = 0; m_irq = 0; m_rest = 0; m_line = 0;
      t_line = "R1"; t_irq = "R1"; t_vld = "R1";
    end else begin
      m_vld = evt_vld;
      t_vld = "R9";
      if (evt_vld) begin
        int ln, ix;
        ln = ref_line(int'(evt_slot), int'(evt_pin));
        ix = ln - 32;
        m_line = ln;
        m_map  = (ix >= 0 && ix < 32);
        t_line = ref_tag(int'(evt_slot));
        if (m_map && edge_mask[ix]) begin
          m_irq = 1; m_rest = 0; t_irq = "R6";
        end else if (m_map) begin
          m_irq = pol_mask[ix]; m_rest = pol_mask[ix]; t_irq = "R7";
        end else begin
          m_irq = m_rest; t_irq = "R8";
        end
      end else begin
        if (t_irq == "R6" && m_irq) t_irq = "R6";
        m_irq = m_rest;
        t_line = "R9";
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(t_vld, "line_vld", int'(line_vld), int'(m_vld));
      chk(t_line, "line_num", int'(line_num), m_line);
      chk(t_line, "line_mapped", int'(line_mapped), int'(m_map));
      chk(t_irq, "cpu_irq", int'(cpu_irq), int'(m_irq));
    end
  end

  task automatic ev(int s, int p);
    @(negedge clk);
    evt_vld = 1'b1; evt_slot = 5'(s); evt_pin = 2'(p);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evt_vld = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: reset state checked during these cycles
    rst = 1'b0;
    idle(2);
    // R2 R3 R4 R5: sweep all slots and pins with level mode, pol all ones
    pol_mask = 32'hFFFF_FFFF;
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        ev(s, p);
        idle(1);
      end
    end
    // R7: level low then hold over idle
    pol_mask = 32'h0;
    ev(9, 2); idle(4);
    pol_mask = 32'h0000_0010;
    ev(6, 3); idle(3);
    // R8: unmapped events while level held high
    ev(0, 1); ev(20, 3); idle(3);
    // R6: pulse from held-high state, then idle
    edge_mask = 32'h0000_0010;
    ev(6, 0); idle(4);
    // R6: back-to-back pulses on different lines
    edge_mask = 32'h0000_3FC0;
    ev(8, 0); ev(10, 1); ev(12, 3); idle(3);
    // R8: pulse followed directly by unmapped event
    ev(11, 2); ev(2, 2); idle(3);
    // R7: mask changes right after the event must not matter
    edge_mask = 32'h0;
    pol_mask = 32'h0000_000F;
    @(negedge clk);
    evt_vld = 1'b1; evt_slot = 5'd5; evt_pin = 2'd1;
    @(negedge clk);
    evt_vld = 1'b0; pol_mask = 32'h0;
    idle(3);
    // mixed sweep with pseudo-random masks
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      edge_mask = $urandom;
      pol_mask = $urandom;
      evt_vld = ($urandom % 3) != 0;
      evt_slot = 5'($urandom % 16);
      evt_pin = 2'($urandom);
    end
    idle(4);
    // R1: reset mid-run with a level held high
    edge_mask = 32'h0; pol_mask = 32'hFFFF_FFFF;
    ev(7, 0); idle(1);
    @(negedge clk); rst = 1'b1;
    idle(2);
    @(negedge clk); rst = 1'b0;
    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule